// File: doc/BRIEF.md
# Receiver On-Window Timer

This block times the awake window of a receiver that is woken periodically. A host loads a 16-bit window length as two byte writes and picks one of four time-base periods with a 2-bit select. The periods stand in the ratio 1 : 4 : 16 : 64, which matches 120 µs, 480 µs, 1920 µs and 7680 µs. The window lasts the programmed count times the chosen period, and the period is derived from a reference tick input.

A wake sequence begins when the duty-cycle enable is high and either the shared handshake line rises or the off-time logic signals that its time is up. The block then waits for a host-wake-done pulse, then for an RF-settle-done pulse, and then opens the on-window. When the window ends, the block looks at the line. If the host is pulling the line low, the receiver stays awake for as long as the line is held low. If the line is high, the block powers down. The handshake line is open-drain: the host pulls it low, and a pullup brings it high when nobody drives it.

Top module: `rx_onwin_timer`

## Requirements
- R1: After reset, `pwr_dn` is 1, `rx_en` is 0 and the stored window count is zero.
- R2: A write with address 0x0B loads bits 15:8 of the window count. A write with address 0x0C loads bits 7:0. Writes to any other address change nothing.
- R3: A `tb_sel` value of 0, 1, 2 or 3 gives a period of BASE_TICKS, 4·BASE_TICKS, 16·BASE_TICKS or 64·BASE_TICKS reference ticks.
- R4: The on-window ends on the clock edge that samples the (N·period)-th reference tick counted from the window start, where N is the stored count. The tick count is cleared at each window start.
- R5: In the sleep state with `drx_en`=1, an `off_done` pulse starts a wake sequence. `rx_en` rises one edge after `host_done` and stays high through the RF settling phase and the window. `pwr_dn` is 0 from the start of the sequence.
- R6: If the line is high when the window ends, the block returns to sleep (`pwr_dn`=1, `rx_en`=0) on that edge.
- R7: If the line is low when the window ends, `rx_en` stays 1 and `pwr_dn` stays 0 for as long as the line stays low.
- R8: A rising edge of the line while `drx_en`=1 restarts the wake sequence from any state (`rx_en`=0, `pwr_dn`=0 on the next edge).
- R9: While `drx_en`=0 the block is held asleep, and `off_done` and line edges have no effect.
- R10: With a stored count of zero, the window ends on the first edge after it opens.
- R11: `tb_sel` is captured when the window opens. Changes to it during the window do not change the window length.
- R12: `dio_level` is 0 while `host_drive_low` is 1 and 1 otherwise, through the pullup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write byte |
| tb_sel | input | 2 | Time-base select |
| ref_tick | input | 1 | Reference tick, one cycle wide |
| drx_en | input | 1 | Duty-cycle receive enable |
| off_done | input | 1 | Off time has elapsed (pulse) |
| host_done | input | 1 | Host wake delay has elapsed (pulse) |
| rf_done | input | 1 | RF settling has finished (pulse) |
| host_drive_low | input | 1 | Host pulls the handshake line low |
| dio_level | output | 1 | Resolved handshake line level |
| rx_en | output | 1 | Receiver enable |
| pwr_dn | output | 1 | Power-down request |

## Verification
The line level follows `host_drive_low` with no register in the path. Every other result is set by the state register and shows one edge after the input that causes it. Window expiry shows on the edge that samples the last reference tick of the window. The bench drives its inputs 1 ns after the falling edge. A reference model advances on each rising edge from the same inputs, and the outputs are compared with that model at every falling edge. Window lengths are measured as the number of falling edges between the edge that opens the window and the first falling edge at which `pwr_dn` is high, and each is compared with N times the period.

// File: rtl/rx_onwin_timer.sv
module rx_onwin_timer #(
  parameter int          BASE_TICKS = 4,
  parameter logic [7:0]  ADDR_HI    = 8'h0B,
  parameter logic [7:0]  ADDR_LO    = 8'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] tb_sel,
  input  logic       ref_tick,
  input  logic       drx_en,
  input  logic       off_done,
  input  logic       host_done,
  input  logic       rf_done,
  input  logic       host_drive_low,
  output logic       dio_level,
  output logic       rx_en,
  output logic       pwr_dn
);
  localparam int CNT_W = 16;
  localparam int PRE_W = $clog2(BASE_TICKS * 64 + 1);

  typedef enum logic [2:0] {S_SLEEP, S_WAKE, S_SETTLE, S_ON, S_HOLD} st_t;

  st_t              state, state_nx;
  logic [CNT_W-1:0] on_cnt, cnt;
  logic [PRE_W-1:0] pre, per;
  logic [1:0]       sel_q;
  logic             line_q, line_rise, base_tick, expire, start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) on_cnt <= '0;
    else if (wr_en && wr_addr == ADDR_HI) on_cnt[15:8] <= wr_data;
    else if (wr_en && wr_addr == ADDR_LO) on_cnt[7:0]  <= wr_data;

  assign dio_level = ~host_drive_low;

  always_ff @(posedge clk) line_q <= dio_level;

  assign line_rise = dio_level & ~line_q;
  assign per       = PRE_W'(BASE_TICKS) << {sel_q, 1'b0};
  assign base_tick = ref_tick && (pre == per - PRE_W'(1));
  assign expire    = (on_cnt == '0) || (base_tick && cnt == on_cnt - CNT_W'(1));

  always_comb begin
    state_nx = state;
    if (!drx_en)        state_nx = S_SLEEP;
    else if (line_rise) state_nx = S_WAKE;
    else
      case (state)
        S_SLEEP:  if (off_done)  state_nx = S_WAKE;
        S_WAKE:   if (host_done) state_nx = S_SETTLE;
        S_SETTLE: if (rf_done)   state_nx = S_ON;
        S_ON:     if (expire)    state_nx = dio_level ? S_SLEEP : S_HOLD;
        default:  state_nx = state;
      endcase
  end

  assign start = (state == S_SETTLE) && (state_nx == S_ON);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_SLEEP;
      pre   <= '0;
      cnt   <= '0;
      sel_q <= '0;
    end else begin
      state <= state_nx;
      if (start) begin
        pre   <= '0;
        cnt   <= '0;
        sel_q <= tb_sel;
      end else if (state == S_ON && ref_tick) begin
        if (base_tick) begin
          pre <= '0;
          cnt <= cnt + CNT_W'(1);
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end
    end

  assign pwr_dn = (state == S_SLEEP);
  assign rx_en  = (state == S_SETTLE) || (state == S_ON) || (state == S_HOLD);
endmodule

// File: rtl/rx_onwin_timer_chk.sv
module rx_onwin_timer_chk #(
  parameter int         PRE_W   = 9,
  parameter logic [7:0] ADDR_HI = 8'h0B,
  parameter logic [7:0] ADDR_LO = 8'h0C
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drx_en,
  input logic             dio_level,
  input logic             rx_en,
  input logic             pwr_dn,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic [15:0]      on_cnt,
  input logic             in_on,
  input logic             expire,
  input logic             line_rise,
  input logic [PRE_W-1:0] pre,
  input logic [PRE_W-1:0] per
);
  assert_hi_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_HI) |=> on_cnt[15:8] == $past(wr_data));

  assert_lo_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_LO) |=> on_cnt[7:0] == $past(wr_data));

  assert_pre_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_on |-> pre < per);

  assert_sleep_on_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_on && expire && drx_en && !line_rise && dio_level) |=> (pwr_dn && !rx_en));

  assert_hold_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_on && expire && drx_en && !dio_level) |=> (rx_en && !pwr_dn));

  assert_rise_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drx_en && $rose(dio_level)) |=> (!pwr_dn && !rx_en));

  assert_disabled_sleeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !drx_en |=> (pwr_dn && !rx_en));

  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_on && on_cnt == 16'd0 && drx_en) |=> !in_on);
endmodule

bind rx_onwin_timer rx_onwin_timer_chk #(
  .PRE_W(PRE_W), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .drx_en(drx_en), .dio_level(dio_level),
  .rx_en(rx_en), .pwr_dn(pwr_dn), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .on_cnt(on_cnt), .in_on(state == S_ON),
  .expire(expire), .line_rise(line_rise), .pre(pre), .per(per)
);

// File: tb/rx_onwin_timer_tb.sv
`timescale 1ns/1ps
module rx_onwin_timer_tb_top;
  localparam int BASE = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ref_tick = 1, drx_en = 0, off_done = 0, host_done = 0, rf_done = 0, host_drive_low = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [1:0] tb_sel = 0;
  logic dio_level, rx_en, pwr_dn;

  int checks = 0, fails = 0, cyc = 0;
  bit sparse = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  rx_onwin_timer #(.BASE_TICKS(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tb_sel(tb_sel), .ref_tick(ref_tick), .drx_en(drx_en), .off_done(off_done),
    .host_done(host_done), .rf_done(rf_done), .host_drive_low(host_drive_low),
    .dio_level(dio_level), .rx_en(rx_en), .pwr_dn(pwr_dn));

  // behavioural model: 0 sleep, 1 wake, 2 settle, 3 on, 4 hold
  int m_st = 0, m_ticks = 0, m_len = 0, m_n = 0;
  bit m_prev = 1;

  always @(posedge clk) begin
    bit lvl, rise;
    lvl  = !host_drive_low;
    rise = lvl && !m_prev;
    m_prev = lvl;
    if (!rst_n) begin
      m_st = 0; m_n = 0;
    end else begin
      if (!drx_en) m_st = 0;
      else if (rise) m_st = 1;
      else case (m_st)
        0: if (off_done) m_st = 1;
        1: if (host_done) m_st = 2;
        2: if (rf_done) begin m_st = 3; m_ticks = 0; m_len = m_n * (BASE << (2 * tb_sel)); end
        3: begin
             if (ref_tick) m_ticks++;
             if (m_n == 0 || m_ticks == m_len) m_st = lvl ? 0 : 4;
           end
        default: ;
      endcase
      if (wr_en && wr_addr == 8'h0B) m_n = (m_n & 255) | (int'(wr_data) << 8);
      else if (wr_en && wr_addr == 8'h0C) m_n = (m_n & 16'hFF00) | int'(wr_data);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(pwr_dn == (m_st == 0), cur_req, pwr_dn, m_st == 0);
      chk(rx_en == (m_st >= 2), cur_req, rx_en, m_st >= 2);
      chk(dio_level == !host_drive_low, "R12", dio_level, !host_drive_low);
    end
    #1 ref_tick = sparse ? (cyc % 3 == 0) : 1'b1;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <60000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step; @(negedge clk); #1; endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step; wr_en = 1; wr_addr = a; wr_data = d;
    step; wr_en = 0;
  endtask

  // wake up, open a window; return the measured cycles until pwr_dn
  task automatic window(input int sel, input int chg_at, output int n);
    step; tb_sel = 2'(sel); off_done = 1;
    step; off_done = 0; host_done = 1;
    step; host_done = 0; rf_done = 1;
    step; rf_done = 0;
    n = 0;
    while (!pwr_dn && n < 20000) begin
      @(negedge clk); n++;
      if (n == chg_at) begin #1 tb_sel = 2'd3; end
    end
  endtask

  initial begin
    int n;
    repeat (3) step;
    cur_req = "R1";
    chk(pwr_dn == 1, "R1", pwr_dn, 1);
    chk(rx_en == 0, "R1", rx_en, 0);
    rst_n = 1; step;
    drx_en = 1;
    cur_req = "R10";
    window(0, -1, n);
    chk(n == 1, "R10", n, 1);

    cur_req = "R2";
    wr(8'h0C, 8'h03);
    wr(8'h0D, 8'h7F);
    wr(8'h0A, 8'h55);
    window(0, -1, n);
    chk(n == 3 * BASE, "R2", n, 3 * BASE);
    cur_req = "R3";
    window(1, -1, n);
    chk(n == 3 * BASE * 4, "R3", n, 3 * BASE * 4);
    wr(8'h0C, 8'h02);
    window(2, -1, n);
    chk(n == 2 * BASE * 16, "R3", n, 2 * BASE * 16);
    wr(8'h0C, 8'h01);
    window(3, -1, n);
    chk(n == BASE * 64, "R3", n, BASE * 64);
    wr(8'h0B, 8'h01); wr(8'h0C, 8'h00);
    cur_req = "R2";
    window(0, -1, n);
    chk(n == 256 * BASE, "R2", n, 256 * BASE);

    cur_req = "R11";
    wr(8'h0B, 8'h00); wr(8'h0C, 8'h05);
    window(0, 3, n);
    chk(n == 5 * BASE, "R11", n, 5 * BASE);

    cur_req = "R4";
    sparse = 1;
    window(0, -1, n);
    chk(n >= 5 * BASE * 3 - 3 && n <= 5 * BASE * 3, "R4", n, 5 * BASE * 3);
    sparse = 0;

    cur_req = "R5";
    step; off_done = 1;
    step; off_done = 0;
    chk(pwr_dn == 0 && rx_en == 0, "R5", {pwr_dn, rx_en}, 0);
    host_done = 1; step; host_done = 0;
    chk(rx_en == 1, "R5", rx_en, 1);
    host_drive_low = 1;
    rf_done = 1; step; rf_done = 0;
    cur_req = "R7";
    repeat (5 * BASE + 10) step;
    chk(rx_en == 1 && pwr_dn == 0, "R7", {rx_en, pwr_dn}, 2);
    cur_req = "R8";
    host_drive_low = 0; step;
    chk(rx_en == 0 && pwr_dn == 0, "R8", {rx_en, pwr_dn}, 0);
    host_done = 1; step; host_done = 0;
    rf_done = 1; step; rf_done = 0;
    repeat (4) step;
    host_drive_low = 1; step;
    host_drive_low = 0; step;
    chk(rx_en == 0 && pwr_dn == 0, "R8", {rx_en, pwr_dn}, 0);
    host_done = 1; step; host_done = 0;
    rf_done = 1; step; rf_done = 0;
    cur_req = "R6";
    repeat (5 * BASE + 2) step;
    chk(pwr_dn == 1 && rx_en == 0, "R6", {pwr_dn, rx_en}, 2);

    cur_req = "R9";
    drx_en = 0; step;
    off_done = 1; host_drive_low = 1; step;
    off_done = 0; host_drive_low = 0; step; step;
    chk(pwr_dn == 1 && rx_en == 0, "R9", {pwr_dn, rx_en}, 2);
    drx_en = 1; step;
    chk(pwr_dn == 1, "R9", pwr_dn, 1);
    cur_req = "R12";
    host_drive_low = 1; step;
    chk(dio_level == 0, "R12", dio_level, 0);
    host_drive_low = 0; step;
    chk(dio_level == 1, "R12", dio_level, 1);
    repeat (4) step;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule